// File: doc/BRIEF.md
# 64-bit SEC-DED ECC Codec

This block protects a 64-bit data word with an 8-bit check byte. Its encoder side forms the check byte for a word about to be stored. Its checker side takes a word and check byte read back from storage and recomputes the check byte from the data. It XORs that result with the stored byte to get a syndrome, and then decides whether the word is clean, has one bad data bit, has one bad check bit, or cannot be repaired. When one bit is bad, the block returns the repaired data and check byte and names the failing bit.

Each check bit is the parity of a fixed subset of data bits, and each subset is given by a 64-bit mask. The column of a data bit is the 8-bit pattern that bit contributes to the syndrome. A single data-bit fault is found by searching for a column equal to the syndrome. The search starts at the lowest data bit, and data bits are always tried before any check bit. A parameter selects whether the results leave the block directly or through a register stage that loads only when a new word is presented.

Top module: `ecc64_secded_codec`

## Requirements
- R1: The check byte is computed so that bit i is the XOR of the data bits selected by mask i, where mask i is a 64-bit value whose bits 63:32 cover data bits 63:32 and whose bits 31:0 cover data bits 31:0. The masks for i = 0..7 are f00fe11e_c33c0ff7, 00ff00ff_00fff0ff, 0f0f0f0f_0f0fff00, 11113333_7777000f, 22224444_8888222f, 44448888_ffff4441, 8888ffff_11118882 and ffff1111_22221114 (hex). As examples, data 1 gives 8'h3B and data 2 gives 8'h5B.
- R2: The syndrome is the recomputed check byte XOR the received check byte. A zero syndrome raises no flag and no index, and the data and check byte pass through unchanged.
- R3: The column of data bit b is bit b of each of the eight masks, with mask i giving syndrome bit i. If the syndrome equals the column of some data bit, the sbe flag is raised and the data index is marked valid. The index is the lowest b whose column matches.
- R4: When a data index is reported, the corrected data is the received data with exactly that bit inverted, and the corrected check byte equals the received one.
- R5: If no data column matches and the syndrome has exactly one bit set, sbe is raised, the check index is marked valid, and the index names the set bit. The corrected check byte inverts that bit, and the data passes unchanged.
- R6: Any other nonzero syndrome raises mbe with neither index valid, and both the data and the check byte pass unchanged.
- R7: sbe and mbe are never raised together, and sbe is raised exactly when one of the two index-valid flags is raised.
- R8: With registered outputs (REG_OUT=1, the default), results appear one clock after a cycle with in_valid high, and out_valid follows in_valid by one clock. All outputs hold their value while in_valid is low. Reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | New word present on the inputs (load enable) |
| enc_data | input | 64 | Word to encode |
| rx_data | input | 64 | Word read back from storage |
| rx_ecc | input | 8 | Check byte read back from storage |
| out_valid | output | 1 | Results below belong to a presented word |
| enc_ecc | output | 8 | Check byte computed for enc_data |
| fix_data | output | 64 | Corrected data |
| fix_ecc | output | 8 | Corrected check byte |
| sbe | output | 1 | Single-bit error found and corrected |
| mbe | output | 1 | Uncorrectable error |
| bad_data_idx | output | 6 | Index of the faulty data bit |
| bad_data_vld | output | 1 | bad_data_idx is meaningful |
| bad_chk_idx | output | 3 | Index of the faulty check bit |
| bad_chk_vld | output | 1 | bad_chk_idx is meaningful |

## Verification
Some properties are checked by assertions on every cycle. These are the exclusion between sbe and mbe and the match between sbe and the index-valid flags. They also cover: a reported data index whose column equals the syndrome, at most one flipped bit in the corrected data and in the corrected check byte, unchanged pass-through on a clean or uncorrectable word, and the one-cycle following and holding behaviour of the register stage. The exact mask contents, the lowest-first choice among data columns, the bit named in each case and the handling of specific double-bit patterns can only be shown by the bench's scenarios. The bench compares these against its own loop-based model of the masks.

// File: rtl/ecc64_pkg.sv
package ecc64_pkg;

  localparam int DW = 64;
  localparam int CW = 8;
  localparam int IW = $clog2(DW);
  localparam int KW = $clog2(CW);

  // Parity masks, one per check bit; bit b of a mask selects data bit b.
  localparam logic [DW-1:0] PMASK [CW] = '{
    64'hf00fe11e_c33c0ff7,
    64'h00ff00ff_00fff0ff,
    64'h0f0f0f0f_0f0fff00,
    64'h11113333_7777000f,
    64'h22224444_8888222f,
    64'h44448888_ffff4441,
    64'h8888ffff_11118882,
    64'hffff1111_22221114
  };

  // Syndrome pattern produced by a fault on data bit b.
  function automatic logic [CW-1:0] column(input int b);
    logic [CW-1:0] c;
    for (int i = 0; i < CW; i++) c[i] = PMASK[i][b];
    return c;
  endfunction

  typedef struct packed {
    logic          sbe;
    logic          mbe;
    logic          dvld;
    logic [IW-1:0] didx;
    logic          cvld;
    logic [KW-1:0] cidx;
  } diag_t;

endpackage

// File: rtl/ecc64_parity_gen.sv
module ecc64_parity_gen
  import ecc64_pkg::*;
(
  input  logic [DW-1:0] data,
  output logic [CW-1:0] chk
);

  for (genvar i = 0; i < CW; i++) begin : g_tree
    assign chk[i] = ^(data & PMASK[i]);
  end

endmodule

// File: rtl/ecc64_locator.sv
module ecc64_locator
  import ecc64_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] syn,
  output diag_t         diag
);

  logic          d_hit;
  logic [IW-1:0] d_idx;
  logic          c_hit;
  logic [KW-1:0] c_idx;

  // Data columns first, lowest bit wins (loop runs downward, last write wins).
  always_comb begin
    d_hit = 1'b0;
    d_idx = '0;
    for (int b = DW - 1; b >= 0; b--) begin
      if (syn == column(b)) begin
        d_hit = 1'b1;
        d_idx = IW'(b);
      end
    end
  end

  always_comb begin
    c_hit = 1'b0;
    c_idx = '0;
    if (!d_hit && $countones(syn) == 1) begin
      c_hit = 1'b1;
      for (int k = CW - 1; k >= 0; k--) begin
        if (syn[k]) c_idx = KW'(k);
      end
    end
  end

  always_comb begin
    diag.dvld = d_hit;
    diag.didx = d_idx;
    diag.cvld = c_hit;
    diag.cidx = c_idx;
    diag.sbe  = d_hit | c_hit;
    diag.mbe  = (syn != '0) && !d_hit && !c_hit;
  end

  // R3: a reported data bit really owns the syndrome pattern
  a_r3_column_match: assert property (@(posedge clk) disable iff (!rst_n)
    diag.dvld |-> (syn == column(int'(diag.didx))));

  // R5: a reported check bit is set in the syndrome
  a_r5_check_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
    diag.cvld |-> syn[diag.cidx]);

endmodule

// File: rtl/ecc64_fixer.sv
module ecc64_fixer
  import ecc64_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] rx_data,
  input  logic [CW-1:0] rx_ecc,
  input  diag_t         diag,
  output logic [DW-1:0] fix_data,
  output logic [CW-1:0] fix_ecc
);

  logic [DW-1:0] dflip;
  logic [CW-1:0] cflip;

  for (genvar b = 0; b < DW; b++) begin : g_dflip
    assign dflip[b] = diag.dvld && (diag.didx == IW'(b));
  end

  for (genvar k = 0; k < CW; k++) begin : g_cflip
    assign cflip[k] = diag.cvld && (diag.cidx == KW'(k));
  end

  assign fix_data = rx_data ^ dflip;
  assign fix_ecc  = rx_ecc ^ cflip;

  // R4: at most one data bit changes
  a_r4_one_data_flip: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fix_data ^ rx_data));

  // R5: at most one check bit changes
  a_r5_one_ecc_flip: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fix_ecc ^ rx_ecc));

  // R6: uncorrectable words pass through untouched
  a_r6_mbe_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    diag.mbe |-> (fix_data == rx_data && fix_ecc == rx_ecc));

endmodule

// File: rtl/ecc64_secded_codec.sv
module ecc64_secded_codec
  import ecc64_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [63:0]   enc_data,
  input  logic [63:0]   rx_data,
  input  logic [7:0]    rx_ecc,
  output logic          out_valid,
  output logic [7:0]    enc_ecc,
  output logic [63:0]   fix_data,
  output logic [7:0]    fix_ecc,
  output logic          sbe,
  output logic          mbe,
  output logic [5:0]    bad_data_idx,
  output logic          bad_data_vld,
  output logic [2:0]    bad_chk_idx,
  output logic          bad_chk_vld
);

  typedef struct packed {
    logic          vld;
    logic [CW-1:0] enc;
    logic [DW-1:0] data;
    logic [CW-1:0] ecc;
    diag_t         diag;
  } result_t;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [CW-1:0] enc_chk;
  logic [CW-1:0] rx_chk;
  logic [CW-1:0] syn;
  diag_t         diag;
  logic [DW-1:0] cor_data;
  logic [CW-1:0] cor_ecc;

  ecc64_parity_gen u_enc (.data(enc_data), .chk(enc_chk));
  ecc64_parity_gen u_rx  (.data(rx_data),  .chk(rx_chk));

  assign syn = rx_chk ^ rx_ecc;

  ecc64_locator u_loc (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .syn   (syn),
    .diag  (diag)
  );

  ecc64_fixer u_fix (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rx_data  (rx_data),
    .rx_ecc   (rx_ecc),
    .diag     (diag),
    .fix_data (cor_data),
    .fix_ecc  (cor_ecc)
  );

  result_t res_d;
  result_t res_q;

  always_comb begin
    res_d.vld  = in_valid;
    res_d.enc  = enc_chk;
    res_d.data = cor_data;
    res_d.ecc  = cor_ecc;
    res_d.diag = diag;
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        res_q <= '0;
      end else begin
        res_q.vld <= res_d.vld;
        if (in_valid) begin
          res_q.enc  <= res_d.enc;
          res_q.data <= res_d.data;
          res_q.ecc  <= res_d.ecc;
          res_q.diag <= res_d.diag;
        end
      end
    end

    // R8: out_valid trails in_valid by one clock
    a_r8_valid_follow: assert property (@(posedge clk) disable iff (!rst_sync_n)
      in_valid |=> out_valid);
    a_r8_valid_drop: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !in_valid |=> !out_valid);
    // R8: results hold without a new word
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !in_valid |=> ($stable(fix_data) && $stable(fix_ecc) && $stable(enc_ecc)
                     && $stable(sbe) && $stable(mbe)));
  end else begin : g_comb
    assign res_q = res_d;
  end

  assign out_valid    = res_q.vld;
  assign enc_ecc      = res_q.enc;
  assign fix_data     = res_q.data;
  assign fix_ecc      = res_q.ecc;
  assign sbe          = res_q.diag.sbe;
  assign mbe          = res_q.diag.mbe;
  assign bad_data_idx = res_q.diag.didx;
  assign bad_data_vld = res_q.diag.dvld;
  assign bad_chk_idx  = res_q.diag.cidx;
  assign bad_chk_vld  = res_q.diag.cvld;

  // R2: a clean word raises nothing and passes unchanged
  a_r2_clean_word: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (syn == '0) |-> (!diag.sbe && !diag.mbe && cor_data == rx_data && cor_ecc == rx_ecc));

  // R7: flags exclusive, sbe tied to exactly one index
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(sbe && mbe));
  a_r7_sbe_one_index: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sbe == ($countones({bad_data_vld, bad_chk_vld}) == 1));

endmodule

// File: tb/ecc64_secded_codec_test.sv
`timescale 1ns/1ps
module ecc64_secded_codec_test;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] enc_data;
  logic [63:0] rx_data;
  logic [7:0]  rx_ecc;
  logic        out_valid;
  logic [7:0]  enc_ecc;
  logic [63:0] fix_data;
  logic [7:0]  fix_ecc;
  logic        sbe;
  logic        mbe;
  logic [5:0]  bad_data_idx;
  logic        bad_data_vld;
  logic [2:0]  bad_chk_idx;
  logic        bad_chk_vld;

  int checks = 0;
  int errors = 0;

  ecc64_secded_codec uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .enc_data(enc_data), .rx_data(rx_data), .rx_ecc(rx_ecc),
    .out_valid(out_valid), .enc_ecc(enc_ecc), .fix_data(fix_data),
    .fix_ecc(fix_ecc), .sbe(sbe), .mbe(mbe),
    .bad_data_idx(bad_data_idx), .bad_data_vld(bad_data_vld),
    .bad_chk_idx(bad_chk_idx), .bad_chk_vld(bad_chk_vld)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Independent model of the specification (R1).
  logic [63:0] tb_mask [8];
  initial begin
    tb_mask[0] = 64'hf00fe11e_c33c0ff7;
    tb_mask[1] = 64'h00ff00ff_00fff0ff;
    tb_mask[2] = 64'h0f0f0f0f_0f0fff00;
    tb_mask[3] = 64'h11113333_7777000f;
    tb_mask[4] = 64'h22224444_8888222f;
    tb_mask[5] = 64'h44448888_ffff4441;
    tb_mask[6] = 64'h8888ffff_11118882;
    tb_mask[7] = 64'hffff1111_22221114;
  end

  function automatic logic [7:0] m_ecc(input logic [63:0] d);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      logic p;
      p = 1'b0;
      for (int j = 0; j < 64; j++) if (tb_mask[i][j]) p ^= d[j];
      r[i] = p;
    end
    return r;
  endfunction

  function automatic logic [7:0] m_col(input int b);
    logic [7:0] c;
    for (int i = 0; i < 8; i++) c[i] = tb_mask[i][b];
    return c;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] e, input logic [63:0] d, input logic [7:0] c);
    @(negedge clk);
    enc_data = e;
    rx_data  = d;
    rx_ecc   = c;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Apply a received word and compare every output against the model.
  task automatic check_rx(input string req, input logic [63:0] d, input logic [7:0] c);
    logic [7:0]  s;
    logic        e_dv, e_cv, e_sbe, e_mbe;
    int          e_di, e_ci;
    logic [63:0] e_data;
    logic [7:0]  e_ecc;
    apply(64'h0, d, c);
    s = m_ecc(d) ^ c;
    e_dv = 1'b0; e_cv = 1'b0; e_di = 0; e_ci = 0;
    for (int b = 0; b < 64 && !e_dv; b++) if (s == m_col(b)) begin e_dv = 1'b1; e_di = b; end
    if (!e_dv && $countones(s) == 1)
      for (int k = 7; k >= 0; k--) if (s[k]) begin e_cv = 1'b1; e_ci = k; end
    e_sbe  = e_dv | e_cv;
    e_mbe  = (s != 8'h0) && !e_sbe;
    e_data = e_dv ? d ^ (64'h1 << e_di) : d;
    e_ecc  = e_cv ? c ^ (8'h1 << e_ci) : c;
    check(req, "sbe", {63'h0, sbe}, {63'h0, e_sbe});
    check(req, "mbe", {63'h0, mbe}, {63'h0, e_mbe});
    check(req, "data_vld", {63'h0, bad_data_vld}, {63'h0, e_dv});
    check(req, "chk_vld", {63'h0, bad_chk_vld}, {63'h0, e_cv});
    if (e_dv) check(req, "data_idx", {58'h0, bad_data_idx}, 64'(e_di));
    if (e_cv) check(req, "chk_idx", {61'h0, bad_chk_idx}, 64'(e_ci));
    check(req, "fix_data", fix_data, e_data);
    check(req, "fix_ecc", {56'h0, fix_ecc}, {56'h0, e_ecc});
    check("R7", "flags exclusive", {63'h0, sbe & mbe}, 64'h0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0;
    enc_data = 64'hffff_ffff_ffff_ffff; rx_data = 64'h1; rx_ecc = 8'h0;
    repeat (3) @(negedge clk);
    check("R8", "reset out_valid", {63'h0, out_valid}, 64'h0);
    check("R8", "reset fix_data", fix_data, 64'h0);
    check("R8", "reset enc_ecc", {56'h0, enc_ecc}, 64'h0);
    check("R8", "reset flags", {62'h0, sbe, mbe}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_encode;
    logic [63:0] pats [6];
    pats[0] = 64'h0; pats[1] = 64'h1; pats[2] = 64'h2;
    pats[3] = 64'hffff_ffff_ffff_ffff; pats[4] = 64'h0123_4567_89ab_cdef;
    pats[5] = 64'h8000_0000_0000_0000;
    for (int i = 0; i < 6; i++) begin
      apply(pats[i], 64'h0, 8'h0);
      check("R1", "enc_ecc", {56'h0, enc_ecc}, {56'h0, m_ecc(pats[i])});
      check("R8", "out_valid", {63'h0, out_valid}, 64'h1);
    end
    apply(64'h1, 64'h0, 8'h0);
    check("R1", "enc_ecc of 1", {56'h0, enc_ecc}, 64'h3b);
    apply(64'h2, 64'h0, 8'h0);
    check("R1", "enc_ecc of 2", {56'h0, enc_ecc}, 64'h5b);
  endtask

  task automatic t_clean;
    logic [63:0] w;
    w = 64'hdead_beef_0bad_f00d;
    for (int i = 0; i < 4; i++) begin
      check_rx("R2", w, m_ecc(w));
      check("R2", "no flag", {62'h0, sbe, mbe}, 64'h0);
      w = {w[62:0], w[63]} ^ 64'h5a5a;
    end
  endtask

  task automatic t_data_flip;
    logic [63:0] w;
    w = 64'h1357_9bdf_2468_ace0;
    for (int b = 0; b < 64; b++) check_rx("R3", w ^ (64'h1 << b), m_ecc(w));
    apply(64'h0, 64'h1, 8'h0);
    check("R3", "bit0 located", {57'h0, bad_data_vld, bad_data_idx}, 64'h40);
    check("R4", "bit0 repaired", fix_data, 64'h0);
    check("R4", "ecc kept", {56'h0, fix_ecc}, 64'h0);
  endtask

  task automatic t_chk_flip;
    logic [63:0] w;
    w = 64'h0f1e_2d3c_4b5a_6978;
    for (int k = 0; k < 8; k++) check_rx("R5", w, m_ecc(w) ^ (8'h1 << k));
    apply(64'h0, 64'h0, 8'h10);
    check("R5", "chk4 located", {60'h0, bad_chk_vld, bad_chk_idx}, 64'hc);
    check("R5", "chk4 repaired", {56'h0, fix_ecc}, 64'h0);
  endtask

  task automatic t_multi;
    logic [63:0] w;
    w = 64'ha5a5_3c3c_0ff0_c0de;
    for (int b = 0; b < 63; b += 7) check_rx("R6", w ^ (64'h3 << b), m_ecc(w));
    for (int k = 0; k < 8; k++) check_rx("R6", w ^ (64'h1 << (k * 5)), m_ecc(w) ^ (8'h1 << k));
    check_rx("R6", w, m_ecc(w) ^ 8'h03);
    apply(64'h0, 64'h0, 8'h03);
    check("R6", "two check bits mbe", {62'h0, sbe, mbe}, 64'h1);
    check("R6", "no index", {62'h0, bad_data_vld, bad_chk_vld}, 64'h0);
    check("R6", "ecc passes", {56'h0, fix_ecc}, 64'h3);
  endtask

  task automatic t_hold;
    logic [63:0] hd;
    logic [7:0]  he;
    apply(64'h1, 64'h4, 8'h0);
    hd = fix_data; he = enc_ecc;
    @(negedge clk);
    enc_data = 64'h2; rx_data = 64'hffff; rx_ecc = 8'hff;
    repeat (3) @(negedge clk);
    check("R8", "hold fix_data", fix_data, hd);
    check("R8", "hold enc_ecc", {56'h0, enc_ecc}, {56'h0, he});
    check("R8", "valid dropped", {63'h0, out_valid}, 64'h0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_encode();
    t_clean();
    t_data_flip();
    t_chk_flip();
    t_multi();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule